// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

The block combines two identical eight-input priority stages into one sixteen-line interrupt controller that drives a single processor interrupt line. The second stage, which serves lines 8 to 15, feeds its request into input 2 of the first stage. Lines 8 to 15 therefore share the priority slot of input 2, and line 2 itself is not available as a source. The block drives `int_o` while a pending, unmasked request outranks everything already in service. The processor then pulses `ack_i`. The block marks the winning line as in service and presents its number, 0 to 15, on `vec_o`.

A sixteen-bit mask register holds back ordinary requests without losing them. An end-of-interrupt strobe retires the highest-priority line in service, so handlers can nest. A separate non-maskable input has its own flag and its own acknowledge, and it never passes through the mask or the priority logic.

Top module: `irq_cascade`

## Requirements
- R1: Each request line is captured on its rising edge into a pending bit. A line held high after being acknowledged raises no second request until it falls and rises again.
- R2: Within one stage, the lower input number always wins.
- R3: The overall order from highest to lowest is 0, 1, 8, 9 … 15, 3, 4 … 7. A winner on the second stage is reported on `vec_o` as 8 plus its stage input, with bit 3 set.
- R4: Line 2 (`irq_i[2]`) has no effect on `int_o` or on `vec_o`.
- R5: A masked line (mask bit = 1) stays pending but cannot raise `int_o`. It is served once it is unmasked. Mask bit 2 masks the whole second stage. A mask write (`mask_we_i` = 1) takes effect from the next cycle.
- R6: While `int_o` is 1, an `ack_i` pulse clears the winner's pending bit and marks it in service. `vec_o` shows its number from the next cycle on. An `ack_i` while `int_o` is 0 changes nothing.
- R7: A pending line whose priority is lower than or equal to the highest line in service keeps `int_o` at 0. A higher-priority line raises `int_o` and pre-empts it.
- R8: `eoi_i` retires the highest-priority line in service. When that line is on the second stage, the cascade slot stays in service for as long as any second-stage line remains in service.
- R9: While a second-stage line is in service, a higher-priority second-stage line can still raise `int_o`. The cascade slot does not block its own stage.
- R10: A rising edge on `nmi_i` sets `nmi_o` from the next cycle, whatever the mask. `nmi_o` stays at 1 until `nmi_ack_i` is pulsed.
- R11: After reset, `int_o`, `nmi_o` and `vec_o` are 0, and nothing is pending, masked or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines, rising-edge captured; bit 2 is unused |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 16 | New mask value, 1 = masked |
| int_o | output | 1 | Processor interrupt request |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| vec_o | output | 4 | Number of the last acknowledged line |
| nmi_i | input | 1 | Non-maskable request, rising-edge captured |
| nmi_ack_i | input | 1 | Non-maskable acknowledge pulse |
| nmi_o | output | 1 | Non-maskable interrupt to the processor |

## Verification
The bench builds the block with its default parameters: eight inputs per stage and the cascade on primary input 2. These are the only values under which the stated overall order and the 4-bit line numbers hold. With them, a table of single-shot patterns covers mixed primary and secondary contention, the dead line 2 and masking. Directed sequences then reach nesting on both stages, the rule that keeps the cascade slot in service while second-stage lines remain in service, held levels, late unmasking and the non-maskable path.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int STAGE_N   = 8;
  localparam int CASC_SLOT = 2;
  localparam int TOTAL_N   = 2 * STAGE_N;
endpackage

// File: rtl/irq_stage.sv
module irq_stage
  import irq_pkg::*;
#(
  parameter int N = STAGE_N,
  parameter logic [N-1:0] LEVEL_MAP = '0,
  parameter logic [N-1:0] NEST_MAP  = '0,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic         ack_i,
  input  logic         eoi_i,
  output logic         req_o,
  output logic [W-1:0] win_o,
  output logic [W-1:0] isr_top_o,
  output logic         isr_any_o,
  output logic         isr_multi_o
);

  function automatic logic [W-1:0] low_idx(input logic [N-1:0] v);
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) low_idx = W'(i);
  endfunction

  logic [N-1:0] prev_q, pend_q, pend_d, isr_q, isr_d;
  logic [N-1:0] edge_v, raw_v, cand_v, win_oh, top_oh;
  logic         cand_any, allow, grant;
  logic [W-1:0] win, top;

  always_comb begin
    edge_v   = req_i & ~prev_q & ~LEVEL_MAP;
    raw_v    = (pend_q & ~LEVEL_MAP) | (req_i & LEVEL_MAP);
    cand_v   = raw_v & ~mask_i;
    cand_any = |cand_v;
    win      = low_idx(cand_v);
    top      = low_idx(isr_q);
    allow    = (isr_q == '0) || (win < top) || ((win == top) && NEST_MAP[win]);
    req_o    = cand_any && allow;
    grant    = ack_i && req_o;
    win_oh   = grant ? (N'(1) << win) : '0;
    top_oh   = (eoi_i && (isr_q != '0)) ? (N'(1) << top) : '0;
    pend_d   = (pend_q | edge_v) & ~win_oh;
    isr_d    = (isr_q & ~top_oh) | win_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= req_i;
      pend_q <= pend_d;
      isr_q  <= isr_d;
    end
  end

  assign win_o       = win;
  assign isr_top_o   = top;
  assign isr_any_o   = (isr_q != '0);
  assign isr_multi_o = ($countones(isr_q) > 1);

  // R1
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~prev_q) == '0);
  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((((pend_q & ~LEVEL_MAP) | (req_i & LEVEL_MAP)) & ~mask_i) != '0));
  // R7
  nest_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && isr_any_o) |-> (win_o <= isr_top_o));
  // R6
  grant_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o) |=> isr_q[$past(win_o)]);

endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irq_pkg::*;
#(
  parameter int N    = STAGE_N,
  parameter int SLOT = CASC_SLOT,
  localparam int W   = $clog2(N),
  localparam int T   = 2 * N,
  localparam int VW  = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [T-1:0]  irq_i,
  input  logic          mask_we_i,
  input  logic [T-1:0]  mask_wdata_i,
  output logic          int_o,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic [VW-1:0] vec_o,
  input  logic          nmi_i,
  input  logic          nmi_ack_i,
  output logic          nmi_o
);

  localparam logic [N-1:0] SLOT_MAP = N'(1) << SLOT;

  logic [T-1:0]  mask_q, mask_d;
  logic [VW-1:0] vec_q, vec_d;
  logic          nmi_q, nmi_d, nmi_prev_q;

  logic          sec_req, sec_any, sec_multi, sec_ack, sec_eoi;
  logic [W-1:0]  sec_win, sec_top;
  logic          prim_req, prim_any, prim_multi, prim_ack, prim_eoi;
  logic [W-1:0]  prim_win, prim_top;
  logic [N-1:0]  prim_in;

  always_comb begin
    prim_in       = irq_i[N-1:0];
    prim_in[SLOT] = sec_req;
  end

  irq_stage #(.N(N), .LEVEL_MAP('0), .NEST_MAP('0)) i_sec (
    .clk(clk), .rst_n(rst_n), .req_i(irq_i[T-1:N]), .mask_i(mask_q[T-1:N]),
    .ack_i(sec_ack), .eoi_i(sec_eoi), .req_o(sec_req), .win_o(sec_win),
    .isr_top_o(sec_top), .isr_any_o(sec_any), .isr_multi_o(sec_multi)
  );

  irq_stage #(.N(N), .LEVEL_MAP(SLOT_MAP), .NEST_MAP(SLOT_MAP)) i_prim (
    .clk(clk), .rst_n(rst_n), .req_i(prim_in), .mask_i(mask_q[N-1:0]),
    .ack_i(prim_ack), .eoi_i(prim_eoi), .req_o(prim_req), .win_o(prim_win),
    .isr_top_o(prim_top), .isr_any_o(prim_any), .isr_multi_o(prim_multi)
  );

  always_comb begin
    int_o    = prim_req;
    prim_ack = ack_i && prim_req;
    sec_ack  = prim_ack && (prim_win == W'(SLOT));
    sec_eoi  = eoi_i && prim_any && (prim_top == W'(SLOT)) && sec_any;
    prim_eoi = eoi_i && prim_any &&
               ((prim_top != W'(SLOT)) || !sec_multi);
    vec_d    = vec_q;
    if (prim_ack)
      vec_d = sec_ack ? {1'b1, sec_win} : {1'b0, prim_win};
    mask_d   = mask_we_i ? mask_wdata_i : mask_q;
    nmi_d    = (nmi_q && !nmi_ack_i) || (nmi_i && !nmi_prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      vec_q      <= '0;
      nmi_q      <= 1'b0;
      nmi_prev_q <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      vec_q      <= vec_d;
      nmi_q      <= nmi_d;
      nmi_prev_q <= nmi_i;
    end
  end

  assign vec_o = vec_q;
  assign nmi_o = nmi_q;

  // R4
  dead_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i[SLOT] && !sec_req) |-> !(prim_req && prim_win == W'(SLOT)));
  // R6
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> $stable(vec_o));
  // R8
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && prim_any && !prim_multi && prim_top != W'(SLOT)) |=> !prim_any);
  // R10
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && !nmi_prev_q) |=> nmi_o);
  // R10
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !nmi_ack_i) |=> nmi_o);

endmodule

// File: tb/test_irq_cascade.sv
module test_irq_cascade;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_i = '0;
  logic        mask_we_i = 1'b0;
  logic [15:0] mask_wdata_i = '0;
  logic        int_o, ack_i = 1'b0, eoi_i = 1'b0;
  logic [3:0]  vec_o;
  logic        nmi_i = 1'b0, nmi_ack_i = 1'b0, nmi_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_cascade i_irq_cascade (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_we_i(mask_we_i),
    .mask_wdata_i(mask_wdata_i), .int_o(int_o), .ack_i(ack_i), .eoi_i(eoi_i),
    .vec_o(vec_o), .nmi_i(nmi_i), .nmi_ack_i(nmi_ack_i), .nmi_o(nmi_o)
  );

  // {mask, requests, expected int_o, expected vec_o}
  localparam logic [36:0] VECS [10] = '{
    {16'h0000, 16'h0020, 1'b1, 4'd5},   // R2
    {16'h0000, 16'h0088, 1'b1, 4'd3},   // R2
    {16'h0000, 16'h1210, 1'b1, 4'd9},   // R3
    {16'h0000, 16'h8002, 1'b1, 4'd1},   // R3
    {16'h0000, 16'h0004, 1'b0, 4'd0},   // R4
    {16'h0040, 16'h0040, 1'b0, 4'd0},   // R5
    {16'h0001, 16'h0101, 1'b1, 4'd8},   // R5
    {16'h0004, 16'h0400, 1'b0, 4'd0},   // R5
    {16'h0000, 16'h4008, 1'b1, 4'd14},  // R3
    {16'h0000, 16'hFFFF, 1'b1, 4'd0}    // R2
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_i = '0; ack_i = 1'b0; eoi_i = 1'b0; mask_we_i = 1'b0;
    nmi_i = 1'b0; nmi_ack_i = 1'b0;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse(input logic [15:0] r);
    irq_i = r; step(); irq_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic eoi();
    eoi_i = 1'b1; step(); eoi_i = 1'b0;
  endtask

  task automatic set_mask(input logic [15:0] m);
    mask_wdata_i = m; mask_we_i = 1'b1; step(); mask_we_i = 1'b0;
  endtask

  initial begin
    #1;
    do_reset();
    // R11
    chk(int_o, 0, "R11 int_o"); chk(nmi_o, 0, "R11 nmi_o"); chk(vec_o, 0, "R11 vec_o");

    for (int k = 0; k < 10; k++) begin
      do_reset();
      set_mask(VECS[k][36:21]);
      pulse(VECS[k][20:5]);
      chk(int_o, VECS[k][4], $sformatf("R3 table int %0d", k));
      if (VECS[k][4]) begin
        ack();
        chk(vec_o, VECS[k][3:0], $sformatf("R6 table vec %0d", k));
      end
    end

    // R7 nesting on primary
    do_reset();
    pulse(16'h0020); ack(); chk(vec_o, 5, "R6 vec 5");
    pulse(16'h0080); chk(int_o, 0, "R7 lower held");
    pulse(16'h0008); chk(int_o, 1, "R7 preempt"); ack(); chk(vec_o, 3, "R7 vec 3");
    eoi(); chk(int_o, 0, "R8 7 still below 5");
    eoi(); chk(int_o, 1, "R8 7 released"); ack(); chk(vec_o, 7, "R8 vec 7");
    eoi();
    // R6 stray ack
    ack(); chk(vec_o, 7, "R6 stray ack"); chk(int_o, 0, "R6 stray ack int");

    // R9 / R8 cascade nesting
    do_reset();
    pulse(16'h1000); ack(); chk(vec_o, 12, "R3 vec 12");
    pulse(16'h0008); chk(int_o, 0, "R7 3 below slot");
    pulse(16'h0200); chk(int_o, 1, "R9 9 over 12"); ack(); chk(vec_o, 9, "R9 vec 9");
    pulse(16'h0800); chk(int_o, 0, "R7 11 below 9");
    eoi(); chk(int_o, 1, "R8 11 over 12"); ack(); chk(vec_o, 11, "R8 vec 11");
    eoi(); chk(int_o, 0, "R8 slot kept");
    eoi(); chk(int_o, 1, "R8 slot retired"); ack(); chk(vec_o, 3, "R8 vec 3");
    eoi();

    // R1 held level
    do_reset();
    irq_i = 16'h0040; step(); ack(); chk(vec_o, 6, "R1 vec 6");
    eoi(); step(); chk(int_o, 0, "R1 held no retrigger");
    irq_i = '0; step(); pulse(16'h0040); chk(int_o, 1, "R1 new edge");

    // R5 late unmask
    do_reset();
    set_mask(16'h0010); pulse(16'h0010); chk(int_o, 0, "R5 masked");
    set_mask(16'h0000); chk(int_o, 1, "R5 unmasked"); ack(); chk(vec_o, 4, "R5 vec 4");

    // R10 NMI
    do_reset();
    set_mask(16'hFFFF);
    nmi_i = 1'b1; step(); chk(nmi_o, 1, "R10 set");
    step(); step(); chk(nmi_o, 1, "R10 hold");
    nmi_ack_i = 1'b1; step(); nmi_ack_i = 1'b0; chk(nmi_o, 0, "R10 ack");
    step(); chk(nmi_o, 0, "R10 level no retrigger");
    nmi_i = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule